// File: doc/BRIEF.md
# Slot-Ring Host Mailbox

This block is the device-side register window of a two-way mailbox between a host and an on-chip engine. Each direction has its own circular buffer of 32-bit slots. The host sees four words. It writes slots into a transmit window and pops slots from a receive window. Two status words carry free-running 8-bit read and write pointers and the buffer depth. Host software finds the fill level by subtracting the pointers modulo 256, and it finds the free space by taking that fill level away from the depth.

The engine side is a plain port. The engine pushes reply slots, pops and inspects host slots, rings a doorbell toward the host, and receives a one-cycle pulse when the host asks for attention. The host status word also holds the interrupt enable, the interrupt status, the host ready bit and the host reset bit. When the host sets reset together with interrupt-generate, both buffers are flushed. The engine ready flag then drops for a fixed number of cycles and comes back on its own. The same hold applies after power-on reset.

Top module: `slotring_mailbox`

## Requirements
- R1: After reset, h_irq is 0. The host status word (byte offset 0x04) reads 0x20000000 with the default depth. The engine status word (offset 0x0C) has bit 3 (engine ready) at 0 and bit 4 (engine in reset) at 1.
- R2: A host write to offset 0x00 appends one slot to the host-to-engine buffer and advances the host status write pointer (bits 23:16). The engine receives the slots in order on e_rdata, and each e_pop advances the read pointer (bits 15:8).
- R3: A host write to offset 0x00 while the host-to-engine buffer holds DEPTH slots is discarded. The pointers are unchanged and h_drop is 1 for the cycle after the write.
- R4: An e_push appends a slot to the engine-to-host buffer. Host reads of offset 0x08 return those slots in order and each read pops one slot. The engine status word shows that buffer's read pointer in bits 15:8 and its write pointer in bits 23:16.
- R5: A host read of offset 0x08 while the engine-to-host buffer is empty returns 0 and leaves both pointers unchanged.
- R6: Pointers are 8 bits wide and wrap from 255 to 0. Storage is indexed by the pointer modulo DEPTH. The fill level stays (write pointer - read pointer) mod 256 across the wrap.
- R7: Bits 31:24 of both status words read DEPTH.
- R8: In the host status word, bit 0 (interrupt enable), bit 3 (host ready) and bit 4 (host reset) read back as last written, and bit 2 (interrupt generate) always reads 0. Writing bit 2 as 1 makes e_ring 1 for exactly the one cycle after the write.
- R9: An e_doorbell pulse sets host status bit 1. Writing bit 1 as 1 clears it, and writing it as 0 leaves it unchanged. h_irq equals bit 1 AND bit 0.
- R10: A host status write with both bit 4 and bit 2 set empties both buffers and sets all pointers to 0. It also drives e_ready and engine status bit 3 to 0 for RST_HOLD cycles, then back to 1. Engine status bit 4 reads 1 while ready is 0.
- R11: Host writes to offset 0x0C have no effect. Engine status bits 2:0 read 0. Accesses whose low two address bits are nonzero are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_sel | input | 1 | Host access strobe, one cycle per access |
| h_we | input | 1 | Host access is a write |
| h_addr | input | 4 | Host byte offset |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, valid while h_sel is high |
| h_irq | output | 1 | Host interrupt, status AND enable |
| h_drop | output | 1 | Host slot write was discarded because the buffer was full |
| e_push | input | 1 | Engine pushes a reply slot |
| e_wdata | input | 32 | Engine reply slot data |
| e_pop | input | 1 | Engine consumes the oldest host slot |
| e_rdata | output | 32 | Oldest host slot, 0 when empty |
| e_h2e_fill | output | 8 | Slots waiting for the engine |
| e_drop | output | 1 | Engine push was discarded because the buffer was full |
| e_doorbell | input | 1 | Engine raises the host interrupt status |
| e_ring | output | 1 | One-cycle attention pulse from the host |
| e_ready | output | 1 | Engine ready flag |

## Verification
On every cycle, the assertions check several properties. The host-to-engine fill level never exceeds the depth. An accepted host write moves the write pointer by exactly one, and a write into a full buffer always raises the drop flag. A pop from an empty receive buffer leaves its pointer still. A reset request drops engine ready on the next cycle. Every ring pulse and every rise of the interrupt status has a matching host write or doorbell one cycle earlier.

Some behaviour is shown only by the bench's scenarios:
- slot ordering through both buffers, checked against scoreboard queues;
- pointer wrap through 256 while data is still pending;
- the exact length of the ready hold;
- write-one-to-clear against write-zero;
- the ignored engine status and misaligned accesses.

// File: rtl/slotring_pkg.sv
package slotring_pkg;
  localparam int SLOT_W = 32;
  localparam int PTR_W  = 8;

  typedef logic [PTR_W-1:0]  ptr_t;
  typedef logic [SLOT_W-1:0] slot_t;

  // Word index of the host window (address bits 3:2)
  typedef enum logic [1:0] {
    WIN_TX   = 2'd0,
    WIN_HCSR = 2'd1,
    WIN_RX   = 2'd2,
    WIN_ECSR = 2'd3
  } win_e;

  // Status word layout, MSB first
  typedef struct packed {
    ptr_t       depth;  // 31:24
    ptr_t       wp;     // 23:16
    ptr_t       rp;     // 15:8
    logic [2:0] rsv;    // 7:5
    logic       rst;    // 4
    logic       rdy;    // 3
    logic       ig;     // 2
    logic       is;     // 1
    logic       ie;     // 0
  } csr_t;

  // Occupied slots: modular pointer difference
  function automatic ptr_t ring_fill(ptr_t wp, ptr_t rp);
    return ptr_t'(wp - rp);
  endfunction

  // Vacant slots given the depth
  function automatic ptr_t ring_free(ptr_t depth, ptr_t wp, ptr_t rp);
    return ptr_t'(depth - ring_fill(wp, rp));
  endfunction
endpackage

// File: rtl/slot_ring.sv
module slot_ring
  import slotring_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  flush,
  input  logic  push,
  input  slot_t push_data,
  input  logic  pop,
  output slot_t head,
  output ptr_t  wptr,
  output ptr_t  rptr,
  output logic  full,
  output logic  empty,
  output logic  push_drop
);
  localparam int   IDX_W   = $clog2(DEPTH);
  localparam ptr_t DEPTH_P = ptr_t'(DEPTH);

  slot_t mem [DEPTH];
  ptr_t  wp_q, rp_q;
  logic  push_ok, pop_ok;

  assign full      = (ring_free(DEPTH_P, wp_q, rp_q) == '0);
  assign empty     = (wp_q == rp_q);
  assign push_ok   = push & ~full & ~flush;
  assign pop_ok    = pop & ~empty & ~flush;
  assign push_drop = push & full & ~flush;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q[IDX_W-1:0]] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else if (flush) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (push_ok) wp_q <= wp_q + ptr_t'(1);
      if (pop_ok)  rp_q <= rp_q + ptr_t'(1);
    end
  end

  assign head = empty ? '0 : mem[rp_q[IDX_W-1:0]];
  assign wptr = wp_q;
  assign rptr = rp_q;
endmodule

// File: rtl/mbx_ready_seq.sv
module mbx_ready_seq #(
  parameter int HOLD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic ready
);
  localparam int CNT_W = $clog2(HOLD + 1);
  localparam logic [CNT_W-1:0] HOLD_C = CNT_W'(HOLD);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= HOLD_C;
    else if (req)           cnt_q <= HOLD_C;
    else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign ready = (cnt_q == '0);
endmodule

// File: rtl/mbx_host_ctl.sv
module mbx_host_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [4:0] wbits,
  input  logic       doorbell,
  output logic       ie,
  output logic       is,
  output logic       hrdy,
  output logic       hrst,
  output logic       ring,
  output logic       rst_req
);
  logic ie_q, is_q, rdy_q, rst_q, ring_q;

  assign rst_req = wr_en & wbits[4] & wbits[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      is_q   <= 1'b0;
      rdy_q  <= 1'b0;
      rst_q  <= 1'b0;
      ring_q <= 1'b0;
    end else begin
      ring_q <= wr_en & wbits[2];
      if (wr_en) begin
        ie_q  <= wbits[0];
        rdy_q <= wbits[3];
        rst_q <= wbits[4];
      end
      // doorbell wins over a same-cycle clear
      if (doorbell)               is_q <= 1'b1;
      else if (wr_en && wbits[1]) is_q <= 1'b0;
    end
  end

  assign ie   = ie_q;
  assign is   = is_q;
  assign hrdy = rdy_q;
  assign hrst = rst_q;
  assign ring = ring_q;
endmodule

// File: rtl/slotring_mailbox.sv
module slotring_mailbox
  import slotring_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int RST_HOLD = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_sel,
  input  logic        h_we,
  input  logic [3:0]  h_addr,
  input  logic [31:0] h_wdata,
  output logic [31:0] h_rdata,
  output logic        h_irq,
  output logic        h_drop,
  input  logic        e_push,
  input  logic [31:0] e_wdata,
  input  logic        e_pop,
  output logic [31:0] e_rdata,
  output logic [7:0]  e_h2e_fill,
  output logic        e_drop,
  input  logic        e_doorbell,
  output logic        e_ring,
  output logic        e_ready
);
  localparam ptr_t DEPTH_P = ptr_t'(DEPTH);

  // Decoded host events (named for the checker)
  win_e win;
  logic acc, host_push, host_pop, csr_wr, rst_req;
  assign win       = win_e'(h_addr[3:2]);
  assign acc       = h_sel & (h_addr[1:0] == 2'b00);
  assign host_push = acc &  h_we & (win == WIN_TX);
  assign host_pop  = acc & ~h_we & (win == WIN_RX);
  assign csr_wr    = acc &  h_we & (win == WIN_HCSR);

  // Host-to-engine ring
  slot_t tx_head;
  ptr_t  tx_wp, tx_rp;
  logic  tx_full, tx_empty, tx_drop;
  slot_ring #(.DEPTH(DEPTH)) u_tx_ring (
    .clk(clk), .rst_n(rst_n), .flush(rst_req),
    .push(host_push), .push_data(h_wdata), .pop(e_pop),
    .head(tx_head), .wptr(tx_wp), .rptr(tx_rp),
    .full(tx_full), .empty(tx_empty), .push_drop(tx_drop)
  );

  // Engine-to-host ring
  slot_t rx_head;
  ptr_t  rx_wp, rx_rp;
  logic  rx_full, rx_empty, rx_drop;
  slot_ring #(.DEPTH(DEPTH)) u_rx_ring (
    .clk(clk), .rst_n(rst_n), .flush(rst_req),
    .push(e_push), .push_data(e_wdata), .pop(host_pop),
    .head(rx_head), .wptr(rx_wp), .rptr(rx_rp),
    .full(rx_full), .empty(rx_empty), .push_drop(rx_drop)
  );

  // Host control bits
  logic c_ie, c_is, c_rdy, c_rst, c_ring;
  mbx_host_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(csr_wr), .wbits(h_wdata[4:0]),
    .doorbell(e_doorbell), .ie(c_ie), .is(c_is), .hrdy(c_rdy),
    .hrst(c_rst), .ring(c_ring), .rst_req(rst_req)
  );

  // Engine ready hold
  logic eng_rdy;
  mbx_ready_seq #(.HOLD(RST_HOLD)) u_rdy (
    .clk(clk), .rst_n(rst_n), .req(rst_req), .ready(eng_rdy)
  );

  // Drop flags, one cycle after the attempt
  logic h_drop_q, e_drop_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_drop_q <= 1'b0;
      e_drop_q <= 1'b0;
    end else begin
      h_drop_q <= tx_drop;
      e_drop_q <= rx_drop;
    end
  end

  // Status words
  csr_t hcsr, ecsr;
  always_comb begin
    hcsr       = '0;
    hcsr.depth = DEPTH_P;
    hcsr.wp    = tx_wp;
    hcsr.rp    = tx_rp;
    hcsr.rst   = c_rst;
    hcsr.rdy   = c_rdy;
    hcsr.is    = c_is;
    hcsr.ie    = c_ie;
    ecsr       = '0;
    ecsr.depth = DEPTH_P;
    ecsr.wp    = rx_wp;
    ecsr.rp    = rx_rp;
    ecsr.rst   = ~eng_rdy;
    ecsr.rdy   = eng_rdy;
  end

  always_comb begin
    h_rdata = '0;
    if (acc && !h_we) begin
      unique case (win)
        WIN_HCSR: h_rdata = hcsr;
        WIN_RX:   h_rdata = rx_head;
        WIN_ECSR: h_rdata = ecsr;
        default:  h_rdata = '0;
      endcase
    end
  end

  assign h_irq      = c_is & c_ie;
  assign h_drop     = h_drop_q;
  assign e_rdata    = tx_head;
  assign e_h2e_fill = ring_fill(tx_wp, tx_rp);
  assign e_drop     = e_drop_q;
  assign e_ring     = c_ring;
  assign e_ready    = eng_rdy;
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int DEPTH = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       host_push,
  input logic       tx_full,
  input logic       h_drop,
  input logic [7:0] e_h2e_fill,
  input logic [7:0] tx_wp,
  input logic       host_pop,
  input logic       rx_empty,
  input logic [7:0] rx_rp,
  input logic       rst_req,
  input logic       e_ready,
  input logic       e_ring,
  input logic       csr_wr,
  input logic       ig_bit,
  input logic       irq_pend,
  input logic       e_doorbell
);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    e_h2e_fill <= 8'(DEPTH));

  a_r3_full_flags: assert property (@(posedge clk) disable iff (!rst_n)
    host_push && tx_full && !rst_req |=> h_drop);

  a_r2_wp_step: assert property (@(posedge clk) disable iff (!rst_n)
    host_push && !tx_full && !rst_req |=> tx_wp == $past(tx_wp) + 8'd1);

  a_r5_empty_pop_still: assert property (@(posedge clk) disable iff (!rst_n)
    host_pop && rx_empty && !rst_req |=> $stable(rx_rp));

  a_r10_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !e_ready);

  a_r8_ring_source: assert property (@(posedge clk) disable iff (!rst_n)
    e_ring |-> $past(csr_wr && ig_bit));

  a_r9_status_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pend) |-> $past(e_doorbell));
endmodule

bind slotring_mailbox mbx_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_push(host_push), .tx_full(tx_full),
  .h_drop(h_drop), .e_h2e_fill(e_h2e_fill), .tx_wp(tx_wp),
  .host_pop(host_pop), .rx_empty(rx_empty), .rx_rp(rx_rp),
  .rst_req(rst_req), .e_ready(e_ready), .e_ring(e_ring),
  .csr_wr(csr_wr), .ig_bit(h_wdata[2]), .irq_pend(c_is),
  .e_doorbell(e_doorbell)
);

// File: tb/slotring_mailbox_bench.sv
module slotring_mailbox_bench;
  localparam int DEPTH = 32;
  localparam int HOLD  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_sel = 0, h_we = 0;
  logic [3:0]  h_addr = '0;
  logic [31:0] h_wdata = '0;
  logic [31:0] h_rdata;
  logic        h_irq, h_drop;
  logic        e_push = 0, e_pop = 0, e_doorbell = 0;
  logic [31:0] e_wdata = '0;
  logic [31:0] e_rdata;
  logic [7:0]  e_h2e_fill;
  logic        e_drop, e_ring, e_ready;

  int compared = 0, mismatched = 0;
  logic [31:0] txq[$];
  logic [31:0] rxq[$];
  bit done = 0;

  always #5 clk = ~clk;

  slotring_mailbox #(.DEPTH(DEPTH), .RST_HOLD(HOLD)) u_slotring_mailbox (
    .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_we(h_we), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq), .h_drop(h_drop),
    .e_push(e_push), .e_wdata(e_wdata), .e_pop(e_pop), .e_rdata(e_rdata),
    .e_h2e_fill(e_h2e_fill), .e_drop(e_drop), .e_doorbell(e_doorbell),
    .e_ring(e_ring), .e_ready(e_ready)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] csr_word(logic [7:0] wp, logic [7:0] rp,
                                           logic [4:0] bits);
    return {8'(DEPTH), wp, rp, 3'b000, bits};
  endfunction

  task automatic host_wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    h_sel = 1; h_we = 1; h_addr = a; h_wdata = d;
    @(posedge clk); #1;
    h_sel = 0; h_we = 0;
  endtask

  task automatic host_rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    h_sel = 1; h_we = 0; h_addr = a;
    #1 d = h_rdata;
    @(posedge clk); #1;
    h_sel = 0;
  endtask

  // Driver: host slot write, expectation queued for the engine monitor
  task automatic tx_send(logic [31:0] v);
    host_wr(4'h0, v);
    txq.push_back(v);
  endtask

  // Monitor: engine consumes a slot and compares with the scoreboard
  task automatic tx_drain(string req);
    logic [31:0] exp;
    @(negedge clk);
    exp = txq.pop_front();
    check(req, e_rdata, exp);
    e_pop = 1;
    @(posedge clk); #1;
    e_pop = 0;
  endtask

  task automatic eng_send(logic [31:0] v);
    @(negedge clk);
    e_push = 1; e_wdata = v;
    @(posedge clk); #1;
    e_push = 0;
    rxq.push_back(v);
  endtask

  task automatic rx_take(string req);
    logic [31:0] d;
    host_rd(4'h8, d);
    check(req, d, rxq.pop_front());
  endtask

  task automatic bell();
    @(negedge clk);
    e_doorbell = 1;
    @(posedge clk); #1;
    e_doorbell = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 / R7: reset state
    check("R1 irq", {31'b0, h_irq}, 32'h0);
    host_rd(4'h4, d); check("R1 R7 host status", d, 32'h2000_0000);
    host_rd(4'hC, d); check("R1 R10 engine status", d, 32'h2000_0010);
    repeat (HOLD + 2) @(posedge clk);
    host_rd(4'hC, d); check("R10 ready after power-on hold", d, 32'h2000_0008);

    // R8: control bits
    host_wr(4'h4, 32'h09);
    check("R8 no ring without IG", {31'b0, e_ring}, 32'h0);
    host_rd(4'h4, d); check("R8 readback", d, csr_word(0, 0, 5'h09));
    host_wr(4'h4, 32'h0D);
    check("R8 ring pulse", {31'b0, e_ring}, 32'h1);
    @(posedge clk); #1;
    check("R8 ring one cycle", {31'b0, e_ring}, 32'h0);
    host_rd(4'h4, d); check("R8 IG reads zero", d, csr_word(0, 0, 5'h09));

    // R9: interrupt status
    bell();
    check("R9 irq raised", {31'b0, h_irq}, 32'h1);
    host_wr(4'h4, 32'h09);
    host_rd(4'h4, d); check("R9 write zero keeps", d, csr_word(0, 0, 5'h0B));
    host_wr(4'h4, 32'h0B);
    check("R9 w1c clears irq", {31'b0, h_irq}, 32'h0);
    host_wr(4'h4, 32'h08);
    bell();
    check("R9 masked irq", {31'b0, h_irq}, 32'h0);
    host_rd(4'h4, d); check("R9 status while masked", d, csr_word(0, 0, 5'h0A));
    host_wr(4'h4, 32'h0A);

    // R2: host to engine ordering
    for (int i = 0; i < 5; i++) tx_send(32'hA000_0000 + i);
    check("R2 fill", {24'b0, e_h2e_fill}, 32'd5);
    host_rd(4'h4, d); check("R2 write pointer", d, csr_word(5, 0, 5'h08));
    for (int i = 0; i < 5; i++) tx_drain("R2 order");

    // R3: full buffer
    for (int i = 0; i < DEPTH; i++) tx_send(32'hB000_0000 + i);
    check("R3 full fill", {24'b0, e_h2e_fill}, 32'(DEPTH));
    host_wr(4'h0, 32'hDEAD_BEEF);
    check("R3 drop flag", {31'b0, h_drop}, 32'h1);
    check("R3 fill unchanged", {24'b0, e_h2e_fill}, 32'(DEPTH));
    for (int i = 0; i < DEPTH; i++) tx_drain("R3 order after drop");

    // R4 / R5: engine to host
    eng_send(32'hC000_0001); eng_send(32'hC000_0002); eng_send(32'hC000_0003);
    host_rd(4'hC, d); check("R4 engine pointers", d, 32'h2003_0008);
    for (int i = 0; i < 3; i++) rx_take("R4 order");
    host_rd(4'h8, d); check("R5 empty read", d, 32'h0);
    host_rd(4'hC, d); check("R5 pointers kept", d, 32'h2003_0308);

    // R11: ignored accesses
    host_wr(4'h1, 32'h1234_5678);
    check("R11 misaligned write", {24'b0, e_h2e_fill}, 32'h0);
    host_wr(4'hC, 32'hFFFF_FFFF);
    host_rd(4'hC, d); check("R11 engine status write", d, 32'h2003_0308);

    // R6: wrap through 256 (host ring at 37/37)
    for (int i = 0; i < 213; i++) begin
      tx_send(32'hD000_0000 + i);
      tx_drain("R6 stream");
    end
    for (int i = 0; i < 10; i++) tx_send(32'hE000_0000 + i);
    check("R6 fill across wrap", {24'b0, e_h2e_fill}, 32'd10);
    host_rd(4'h4, d); check("R6 wrapped pointers", d, csr_word(8'd4, 8'd250, 5'h08));
    for (int i = 0; i < 10; i++) tx_drain("R6 order across wrap");

    // R10: reset request
    tx_send(32'h1); tx_send(32'h2);
    eng_send(32'h3); eng_send(32'h4);
    txq.delete(); rxq.delete();
    host_wr(4'h4, 32'h14);
    check("R10 ready low", {31'b0, e_ready}, 32'h0);
    check("R10 flush host ring", {24'b0, e_h2e_fill}, 32'h0);
    repeat (HOLD - 1) @(posedge clk);
    #1 check("R10 ready held", {31'b0, e_ready}, 32'h0);
    @(posedge clk);
    #1 check("R10 ready back", {31'b0, e_ready}, 32'h1);
    host_rd(4'hC, d); check("R10 engine status", d, 32'h2000_0008);
    host_rd(4'h8, d); check("R10 rx flushed", d, 32'h0);
    host_rd(4'h4, d); check("R10 host status", d, csr_word(0, 0, 5'h10));
    host_wr(4'h4, 32'h0C);
    host_rd(4'h4, d); check("R8 host ready declared", d, csr_word(0, 0, 5'h08));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule